// File: doc/BRIEF.md
# Word-Banked Instruction Cache Read Path

This block is the read side of a direct-mapped instruction cache whose data array is cut into one bank per 32-bit instruction word. Every read carries a word-enable vector next to the fetch address, and only the banks whose enable bit is set are clocked for that access. A fetch unit that knows which words of the next line it will use can read any run of words, or any other mask, in one access and leave the other banks idle.

The tag array is read on every request. One cycle after a request the block reports whether the line was present. It returns the enabled words in their line positions, with zero in every disabled position. It also reports how many banks delivered useful words, which is the figure an energy estimate can accumulate. A miss returns no data and a count of zero. A refill port writes a whole line in one cycle and marks it valid. The next-level memory that supplies refills is outside the block.

Top module: `wbic_top`

## Requirements
- R1: After reset, rd_valid, rd_hit and rd_miss are low, rd_bank_cnt is 0 and rd_data is all zero, and every line is invalid, so the first read of any address misses.
- R2: rd_valid is high in exactly the cycles that follow a cycle with rd_req high; a refill with no request leaves rd_valid low.
- R3: With OFF_W = log2(WORDS)+2, the line index is rd_addr[OFF_W+IDX_W-1:OFF_W] and the tag is the bits above it; the low OFF_W bits do not affect the result. A response is a hit when the indexed line is valid and its tag matches, and a miss otherwise. rd_hit and rd_miss are never high together and both are low when rd_valid is low.
- R4: On a hit, slice i of rd_data (bits i*32 +: 32) holds word i of the line when rd_word_en[i] was 1 in the request cycle, and zero when it was 0. Any mask pattern is accepted, including every contiguous run, a single word and the empty mask.
- R5: rd_bank_cnt equals the number of set bits in the request's rd_word_en on a hit, and is 0 on a miss or when no response is given.
- R6: A refill (fill_en) writes all WORDS words of the line addressed by fill_addr in one cycle and sets that line's valid bit with the new tag, replacing any line previously held at that index.
- R7: When a refill and a read reach the same line in the same cycle, the read returns the line's contents and tag state from before the refill.
- R8: With WORDS set to 4 the line is 4 words of 32 bits, the offset field is 4 bits wide, and the same mask, data placement and count rules hold, with counts up to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the fetch |
| rd_word_en | input | WORDS | One bit per word bank; set bits are read |
| rd_valid | output | 1 | Response present this cycle |
| rd_hit | output | 1 | Response is a hit |
| rd_miss | output | 1 | Response is a miss |
| rd_data | output | WORDS*WORD_W | Line words, disabled positions zero |
| rd_bank_cnt | output | CNT_W | Banks that delivered useful words |
| fill_en | input | 1 | Refill strobe |
| fill_addr | input | ADDR_W | Byte address of the refilled line |
| fill_line | input | WORDS*WORD_W | Full line, word i in bits i*WORD_W +: WORD_W |

## Verification
The hardest case to reach from the ports is a refill and a read that land on the same line in the same cycle, together with the eviction that follows. The directed part issues a refill with a new tag to an index holding a known line while reading the old tag there. It then checks that the old data comes back, and that on the next reads the old tag misses and the new one hits. The random part draws tags from a set of four and indexes from a set of eight, so that refills, evictions and simultaneous fill-and-read collisions recur many times under random masks.

// File: rtl/wbic_pkg.sv
package wbic_pkg;

    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,
        OUT_HIT  = 2'd1,
        OUT_MISS = 2'd2
    } outcome_e;

    localparam int MAX_WORDS = 16;

    function automatic outcome_e outcome_of(input logic req, input logic hit);
        if (!req)
            return OUT_IDLE;
        return hit ? OUT_HIT : OUT_MISS;
    endfunction

    function automatic logic [4:0] ones16(input logic [MAX_WORDS-1:0] v);
        logic [4:0] n;
        n = '0;
        for (int i = 0; i < MAX_WORDS; i++)
            n = n + 5'(v[i]);
        return n;
    endfunction

endpackage

// File: rtl/wbic_tag_array.sv
module wbic_tag_array #(
    parameter int LINES = 64,
    parameter int TAG_W = 21,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit
);
    logic [LINES-1:0] valid_r;
    logic [TAG_W-1:0] tag_r [LINES];

    // Lookup sees the state before any refill in the same cycle.
    assign lk_hit = valid_r[lk_idx] && (tag_r[lk_idx] == lk_tag);

    always_ff @(posedge clk) begin
        if (rst)
            valid_r <= '0;
        else if (fill_en)
            valid_r[fill_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_en)
            tag_r[fill_idx] <= fill_tag;
    end
endmodule

// File: rtl/wbic_word_bank.sv
module wbic_word_bank #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_q;

    // Read register only toggles when this bank is enabled.
    always_ff @(posedge clk) begin
        if (rd_en)
            rd_q <= mem[rd_idx];
        if (wr_en)
            mem[wr_idx] <= wr_word;
    end

    assign rd_word = rd_q;
endmodule

// File: rtl/wbic_act_counter.sv
module wbic_act_counter
    import wbic_pkg::*;
#(
    parameter int WORDS = 8,
    localparam int CNT_W = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [WORDS-1:0] mask,
    input  logic             hit_q,
    output logic [CNT_W-1:0] cnt
);
    logic [MAX_WORDS-1:0] wide_mask;
    logic [4:0]           pc_d;
    logic [CNT_W-1:0]     pc_q;

    always_comb begin
        wide_mask = '0;
        wide_mask[WORDS-1:0] = mask;
        pc_d = ones16(wide_mask);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (req)
            pc_q <= CNT_W'(pc_d);
        else
            pc_q <= '0;
    end

    assign cnt = hit_q ? pc_q : '0;
endmodule

// File: rtl/wbic_top.sv
module wbic_top
    import wbic_pkg::*;
#(
    parameter int LINES  = 64,
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 32,
    localparam int OFF_W  = $clog2(WORDS) + 2,
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W = WORDS * WORD_W,
    localparam int CNT_W  = $clog2(WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WORDS-1:0]  rd_word_en,
    output logic              rd_valid,
    output logic              rd_hit,
    output logic              rd_miss,
    output logic [LINE_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rd_bank_cnt,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0] fill_line
);
    logic [IDX_W-1:0] rd_idx, fill_idx;
    logic [TAG_W-1:0] rd_tag, fill_tag;
    logic             unused_offsets;
    logic             lk_hit;
    outcome_e         outcome_q;
    logic [WORDS-1:0] mask_q;
    logic             hit_q;

    assign rd_idx   = rd_addr[OFF_W +: IDX_W];
    assign rd_tag   = rd_addr[ADDR_W-1 -: TAG_W];
    assign fill_idx = fill_addr[OFF_W +: IDX_W];
    assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
    assign unused_offsets = ^{rd_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

    wbic_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .fill_en  (fill_en),
        .fill_idx (fill_idx),
        .fill_tag (fill_tag),
        .lk_idx   (rd_idx),
        .lk_tag   (rd_tag),
        .lk_hit   (lk_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            outcome_q <= OUT_IDLE;
            mask_q    <= '0;
        end else begin
            outcome_q <= outcome_of(rd_req, lk_hit);
            mask_q    <= rd_req ? rd_word_en : '0;
        end
    end

    assign hit_q    = (outcome_q == OUT_HIT);
    assign rd_valid = (outcome_q != OUT_IDLE);
    assign rd_hit   = hit_q;
    assign rd_miss  = (outcome_q == OUT_MISS);

    for (genvar w = 0; w < WORDS; w++) begin : g_bank
        logic [WORD_W-1:0] bank_word;

        wbic_word_bank #(.DEPTH(LINES), .WORD_W(WORD_W)) u_bank (
            .clk     (clk),
            .wr_en   (fill_en),
            .wr_idx  (fill_idx),
            .wr_word (fill_line[w*WORD_W +: WORD_W]),
            .rd_en   (rd_req && rd_word_en[w]),
            .rd_idx  (rd_idx),
            .rd_word (bank_word)
        );

        assign rd_data[w*WORD_W +: WORD_W] =
            (hit_q && mask_q[w]) ? bank_word : '0;
    end

    wbic_act_counter #(.WORDS(WORDS)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .req   (rd_req),
        .mask  (rd_word_en),
        .hit_q (hit_q),
        .cnt   (rd_bank_cnt)
    );
endmodule

// File: rtl/wbic_checker.sv
module wbic_checker #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    rd_req,
    input logic [WORDS-1:0]        rd_word_en,
    input logic                    rd_valid,
    input logic                    rd_hit,
    input logic                    rd_miss,
    input logic [WORDS*WORD_W-1:0] rd_data,
    input logic [CNT_W-1:0]        rd_bank_cnt
);
    AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid) else $error("request without response"); // R2
    AST_NOREQ_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid) else $error("response without request"); // R2
    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_hit != rd_miss)) else $error("hit and miss clash"); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (!rd_hit && !rd_miss && rd_bank_cnt == '0)) else $error("idle not quiet"); // R3
    AST_MISS_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        rd_miss |-> (rd_bank_cnt == '0 && rd_data == '0)) else $error("miss counted"); // R5
    AST_HIT_COUNT: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> (32'(rd_bank_cnt) == 32'($countones($past(rd_word_en)))))
        else $error("bank count mismatch"); // R5

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        AST_DISABLED_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
            (rd_valid && !$past(rd_word_en[i])) |-> (rd_data[i*WORD_W +: WORD_W] == '0))
            else $error("disabled word not zero"); // R4
    end
endmodule

bind wbic_top wbic_checker #(.WORDS(WORDS), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_req      (rd_req),
    .rd_word_en  (rd_word_en),
    .rd_valid    (rd_valid),
    .rd_hit      (rd_hit),
    .rd_miss     (rd_miss),
    .rd_data     (rd_data),
    .rd_bank_cnt (rd_bank_cnt)
);

// File: tb/wbic_top_bench.sv
module wbic_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS  = 8;
    localparam int OFF_W  = 5;
    localparam int IDX_W  = 6;
    localparam int LINE_W = 256;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_req = 1'b0;
    logic [31:0]       rd_addr = '0;
    logic [7:0]        rd_word_en = '0;
    logic              rd_valid, rd_hit, rd_miss;
    logic [LINE_W-1:0] rd_data;
    logic [3:0]        rd_bank_cnt;
    logic              fill_en = 1'b0;
    logic [31:0]       fill_addr = '0;
    logic [LINE_W-1:0] fill_line = '0;

    // Four-word configuration
    logic         w4_req = 1'b0;
    logic [31:0]  w4_addr = '0;
    logic [3:0]   w4_en = '0;
    logic         w4_valid, w4_hit, w4_miss;
    logic [127:0] w4_data;
    logic [2:0]   w4_cnt;
    logic         w4_fill = 1'b0;
    logic [31:0]  w4_faddr = '0;
    logic [127:0] w4_fline = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbic_top u_wbic_top (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_word_en(rd_word_en), .rd_valid(rd_valid), .rd_hit(rd_hit),
        .rd_miss(rd_miss), .rd_data(rd_data), .rd_bank_cnt(rd_bank_cnt),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_line(fill_line)
    );

    wbic_top #(.WORDS(4)) u_wbic_top_w4 (
        .clk(clk), .rst(rst), .rd_req(w4_req), .rd_addr(w4_addr),
        .rd_word_en(w4_en), .rd_valid(w4_valid), .rd_hit(w4_hit),
        .rd_miss(w4_miss), .rd_data(w4_data), .rd_bank_cnt(w4_cnt),
        .fill_en(w4_fill), .fill_addr(w4_faddr), .fill_line(w4_fline)
    );

    // Reference state
    logic              ref_valid [64];
    logic [20:0]       ref_tag   [64];
    logic [LINE_W-1:0] ref_line  [64];

    task automatic chk(input string req, input string what,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int tag, input int idx, input int off);
        return (32'(tag) << (OFF_W + IDX_W)) | (32'(idx) << OFF_W) | (32'(off) & 32'h1f);
    endfunction

    function automatic logic [LINE_W-1:0] rand_line();
        logic [LINE_W-1:0] l;
        for (int i = 0; i < WORDS; i++)
            l[i*32 +: 32] = $urandom;
        return l;
    endfunction

    function automatic logic [LINE_W-1:0] exp_data(input logic hit, input logic [LINE_W-1:0] line,
                                                   input logic [7:0] m);
        logic [LINE_W-1:0] d;
        d = '0;
        for (int i = 0; i < WORDS; i++)
            if (hit && m[i])
                d[i*32 +: 32] = line[i*32 +: 32];
        return d;
    endfunction

    function automatic int ones8(input logic [7:0] m);
        int n;
        n = 0;
        for (int i = 0; i < 8; i++)
            n += int'(m[i]);
        return n;
    endfunction

    // Starts and ends at a falling edge.
    task automatic step(input logic req, input logic [31:0] a, input logic [7:0] m,
                        input logic fe, input logic [31:0] fa, input logic [LINE_W-1:0] fl,
                        input string rq);
        int idx;
        logic [20:0] tg;
        logic eh;
        logic [LINE_W-1:0] ed;
        int fidx;
        rd_req = req; rd_addr = a; rd_word_en = m;
        fill_en = fe; fill_addr = fa; fill_line = fl;
        idx = int'(a[OFF_W +: IDX_W]);
        tg  = a[31 -: 21];
        eh  = ref_valid[idx] && (ref_tag[idx] == tg);
        ed  = exp_data(eh, ref_line[idx], m);
        @(posedge clk);
        if (fe) begin
            fidx = int'(fa[OFF_W +: IDX_W]);
            ref_valid[fidx] = 1'b1;
            ref_tag[fidx]   = fa[31 -: 21];
            ref_line[fidx]  = fl;
        end
        @(negedge clk);
        chk("R2", "valid", LINE_W'(rd_valid), LINE_W'(req));
        if (req) begin
            chk("R3", "hit", LINE_W'(rd_hit), LINE_W'(eh));
            chk("R3", "miss", LINE_W'(rd_miss), LINE_W'(!eh));
            chk(rq, "data", rd_data, ed);
            chk("R5", "count", LINE_W'(rd_bank_cnt), LINE_W'(eh ? ones8(m) : 0));
        end else begin
            chk("R3", "idle hit/miss", LINE_W'({rd_hit, rd_miss}), '0);
            chk("R5", "idle count", LINE_W'(rd_bank_cnt), '0);
        end
        rd_req = 1'b0; fill_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [LINE_W-1:0] la, lb;
        logic [31:0] a_old, a_new;
        logic [127:0] l4;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            ref_valid[i] = 1'b0; ref_tag[i] = '0; ref_line[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of outputs
        chk("R1", "valid after reset", LINE_W'(rd_valid), '0);
        chk("R1", "hit/miss after reset", LINE_W'({rd_hit, rd_miss}), '0);
        chk("R1", "count after reset", LINE_W'(rd_bank_cnt), '0);
        chk("R1", "data after reset", rd_data, '0);
        // R1: lines invalid after reset
        step(1'b1, mk_addr(0, 0, 0), 8'hff, 1'b0, '0, '0, "R1");
        step(1'b1, mk_addr(7, 63, 0), 8'hff, 1'b0, '0, '0, "R1");

        // R6: refill then full-line hit
        la = rand_line();
        step(1'b0, '0, '0, 1'b1, mk_addr(5, 3, 0), la, "R6");
        step(1'b1, mk_addr(5, 3, 0), 8'hff, 1'b0, '0, '0, "R6");
        // R4/R5: mask patterns
        step(1'b1, mk_addr(5, 3, 0), 8'h00, 1'b0, '0, '0, "R4");
        step(1'b1, mk_addr(5, 3, 0), 8'h38, 1'b0, '0, '0, "R4");
        step(1'b1, mk_addr(5, 3, 0), 8'h80, 1'b0, '0, '0, "R4");
        step(1'b1, mk_addr(5, 3, 0), 8'h01, 1'b0, '0, '0, "R4");
        step(1'b1, mk_addr(5, 3, 0), 8'hf0, 1'b0, '0, '0, "R4");
        step(1'b1, mk_addr(5, 3, 0), 8'ha5, 1'b0, '0, '0, "R4");
        // R3: offset bits ignored, other tag misses
        step(1'b1, mk_addr(5, 3, 31), 8'h0f, 1'b0, '0, '0, "R3");
        step(1'b1, mk_addr(6, 3, 0), 8'hff, 1'b0, '0, '0, "R3");

        // R7: same-cycle refill with a new tag while reading the old one
        lb = rand_line();
        a_old = mk_addr(5, 3, 4);
        a_new = mk_addr(9, 3, 8);
        step(1'b1, a_old, 8'hff, 1'b1, a_new, lb, "R7");
        // R6: eviction
        step(1'b1, a_old, 8'hff, 1'b0, '0, '0, "R6");
        step(1'b1, a_new, 8'h7e, 1'b0, '0, '0, "R6");
        // R7: refill and read of the same invalid line
        step(1'b1, mk_addr(2, 40, 0), 8'hff, 1'b1, mk_addr(2, 40, 0), rand_line(), "R7");
        step(1'b1, mk_addr(2, 40, 0), 8'hff, 1'b0, '0, '0, "R6");

        // Random traffic over a small tag/index space
        for (int k = 0; k < 600; k++) begin
            logic rq, fe;
            logic [7:0] m;
            int s, e;
            rq = ($urandom % 4) != 0;
            fe = ($urandom % 3) == 0;
            if (($urandom % 2) == 0) begin
                s = int'($urandom % 8);
                e = s + int'($urandom % (8 - s));
                m = '0;
                for (int b = s; b <= e; b++) m[b] = 1'b1;
            end else begin
                m = 8'($urandom);
            end
            step(rq, mk_addr(int'($urandom % 4), int'($urandom % 8), int'($urandom % 32)), m,
                 fe, mk_addr(int'($urandom % 4), int'($urandom % 8), 0), rand_line(), "R4");
        end

        // R8: four-word configuration
        l4 = {32'hdddd0003, 32'hcccc0002, 32'hbbbb0001, 32'haaaa0000};
        w4_fill = 1'b1; w4_faddr = (32'd3 << 10) | (32'd5 << 4); w4_fline = l4;
        @(posedge clk); @(negedge clk);
        w4_fill = 1'b0;
        w4_req = 1'b1; w4_addr = (32'd3 << 10) | (32'd5 << 4) | 32'hc; w4_en = 4'b0110;
        @(posedge clk); @(negedge clk);
        chk("R8", "w4 hit", LINE_W'(w4_hit), LINE_W'(1));
        chk("R8", "w4 data", LINE_W'(w4_data), LINE_W'({32'h0, 32'hcccc0002, 32'hbbbb0001, 32'h0}));
        chk("R8", "w4 count", LINE_W'(w4_cnt), LINE_W'(2));
        w4_en = 4'b1111;
        @(posedge clk); @(negedge clk);
        chk("R8", "w4 full data", LINE_W'(w4_data), LINE_W'(l4));
        chk("R8", "w4 full count", LINE_W'(w4_cnt), LINE_W'(4));
        w4_addr = (32'd3 << 10) | (32'd6 << 4);
        @(posedge clk); @(negedge clk);
        chk("R8", "w4 miss", LINE_W'({w4_hit, w4_miss, w4_cnt}), LINE_W'(5'b01000));
        w4_req = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule